// File: doc/BRIEF.md
# Shared Interrupt Link Steering Router

The block steers eight shared, level-sensitive interrupt links onto a bank of sixteen legacy IRQ request lines. Each link has one routing register that holds a disable flag and a 4-bit IRQ number. Software reaches these registers through a small indexed port. Link indices run from 1 to 8, and index 0 stands for "no link". Devices that share a link report their state with single-cycle raise and drop event pulses. The block keeps a count of active sources for each link, so a link stays asserted until its last source has dropped.

A link drives an IRQ line only when it is routed. That means its disable flag is clear and its IRQ number is one of the legal targets: 3 to 7, 9 to 12, 14 or 15. Each IRQ output is the OR of every link that is active, routed and pointing at that line, so several links may share one line. When software rewrites the routing of a live link, the request moves from the old line to the new one at a single clock edge, with no cycle in which both lines or neither line is driven by that link.

Top module: `pirq_router`

## Requirements
- R1: After reset every link register reads 0x80 (disabled, IRQ field 0), every active count is zero and `irq_out` is all zero.
- R2: A write to index 1..8 stores only bit 7 (disable) and bits 3:0 (IRQ number). The read returns that masked value, so bits 6:4 read as 0. A write to index 0 or 9..15 changes no register. A read of index 0 or 9..15 returns 0x00.
- R3: A link is routed only when bit 7 is 0 and bits 3:0 hold 3..7, 9..12, 14 or 15. An active link whose field holds 0, 1, 2, 8 or 13 drives no IRQ line.
- R4: A raise pulse on bit i of `evt_raise` increments the count of link i+1. An active (count > 0), routed link drives `irq_out[n]`, where n is its IRQ field, from the cycle after the pulse.
- R5: A drop pulse decrements the link's count. The line is released after the count returns to 0. A drop pulse while the count is 0 is ignored, and the count does not wrap.
- R6: The count is 4 bits wide and saturates at 15. Further raise pulses leave it at 15, so 15 drop pulses then release the line.
- R7: A raise and a drop pulse for the same link in the same cycle cancel, and the count is unchanged.
- R8: A write that changes a live link's register moves its request from the old line (if routed) to the new line (if routed) in the cycle after the write. Writing 0x80 releases the link's line. A write of the already stored value changes nothing.
- R9: `irq_out[n]` is the OR of all active, routed links whose field is n. It stays high while any such link remains active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Link index for the write (1..8 valid) |
| wr_data | input | 8 | Write data, masked to bits 7 and 3:0 |
| rd_idx | input | 4 | Link index for the combinational read |
| rd_data | output | 8 | Stored value of the addressed link, 0 for invalid index |
| evt_raise | input | 8 | Per-link source raise pulses (bit i is link i+1) |
| evt_drop | input | 8 | Per-link source drop pulses (bit i is link i+1) |
| irq_out | output | 16 | Legacy IRQ request levels, bit n is IRQ n |

## Verification
The routing is tried with legal targets, with the illegal values 0, 2, 8 and 13, and with disabled links. These patterns separate the legality check from plain field decoding. Single-source raise and drop pulses, long bursts past saturation, drops at zero and simultaneous raise and drop pulses each separate correct counting from wrap, overflow and priority errors. Two links sharing one line, with the sources dropping in turn, show an OR rather than a last-writer behaviour. Rewrites of a live link to a new line, to disabled, back to routed and to the same value show that the request moves in one edge and that redundant writes are inert.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  parameter int NUM_LINKS = 8;
  parameter int IRQ_LINES = 16;
  parameter int REG_W     = 8;
  parameter int IRQ_W     = 4;
  parameter int CNT_W     = 4;
  parameter int DIS_BIT   = 7;
  parameter int IDX_W     = $clog2(NUM_LINKS + 1);
  // legal targets: 3-7, 9-12, 14, 15
  parameter logic [IRQ_LINES-1:0] LEGAL_MASK = 16'hDEF8;
  parameter logic [REG_W-1:0] KEEP_MASK = (REG_W'(1) << DIS_BIT) | REG_W'((1 << IRQ_W) - 1);
  parameter logic [REG_W-1:0] RESET_VAL = REG_W'(1) << DIS_BIT;

  function automatic logic [REG_W-1:0] mask_reg(input logic [REG_W-1:0] v);
    return v & KEEP_MASK;
  endfunction

  function automatic logic [IRQ_W-1:0] irq_field(input logic [REG_W-1:0] v);
    return v[IRQ_W-1:0];
  endfunction

  function automatic logic irq_legal(input logic [IRQ_W-1:0] n);
    return LEGAL_MASK[n];
  endfunction

  function automatic logic link_routed(input logic [REG_W-1:0] v);
    return !v[DIS_BIT] && irq_legal(irq_field(v));
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic up, input logic dn);
    logic [CNT_W-1:0] r;
    r = c;
    if (up && !dn && c != {CNT_W{1'b1}}) r = c + 1'b1;
    else if (dn && !up && c != '0)       r = c - 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pirq_link_regs.sv
module pirq_link_regs
  import pirq_pkg::*;
#(
  parameter int N  = NUM_LINKS,
  parameter int RW = REG_W,
  parameter int IW = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [RW-1:0]     wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [RW-1:0]     rd_data,
  output logic [N-1:0][RW-1:0] regs_q,
  output logic [N-1:0]      reg_change
);
  logic [RW-1:0] wr_masked;
  logic [N-1:0]  wr_hit;

  assign wr_masked = mask_reg(wr_data);

  for (genvar i = 0; i < N; i++) begin : g_reg
    assign wr_hit[i]     = wr_en && (wr_idx == IW'(i + 1));
    assign reg_change[i] = wr_hit[i] && (wr_masked != regs_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             regs_q[i] <= RESET_VAL;
      else if (reg_change[i]) regs_q[i] <= wr_masked;
    end

    AST_SAME_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit[i] && !reg_change[i]) |=> $stable(regs_q[i])); // R8
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rd_idx == IW'(i + 1)) rd_data = regs_q[i];
  end

  AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~KEEP_MASK) == '0); // R2
  AST_BAD_IDX_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0 || rd_idx > IW'(N)) |-> rd_data == '0); // R2
endmodule

// File: rtl/pirq_link_counter.sv
module pirq_link_counter
  import pirq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up,
  input  logic          dn,
  output logic [CW-1:0] cnt_q,
  output logic          active
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, up, dn);
  end

  assign active = (cnt_q != '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dn && !up) |=> cnt_q == '0); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && up && !dn) |=> cnt_q == CNT_MAX); // R6
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> $stable(cnt_q)); // R7
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !dn && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R4
endmodule

// File: rtl/pirq_irq_combiner.sv
module pirq_irq_combiner
  import pirq_pkg::*;
#(
  parameter int N  = NUM_LINKS,
  parameter int L  = IRQ_LINES,
  parameter int RW = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      active,
  input  logic [N-1:0][RW-1:0] regs_q,
  output logic [L-1:0]      irq_out
);
  logic [N-1:0] drive;

  for (genvar i = 0; i < N; i++) begin : g_drv
    assign drive[i] = active[i] && link_routed(regs_q[i]);
  end

  for (genvar n = 0; n < L; n++) begin : g_line
    logic [N-1:0] hits;
    for (genvar i = 0; i < N; i++) begin : g_hit
      assign hits[i] = drive[i] && (irq_field(regs_q[i]) == IRQ_W'(n));
    end
    assign irq_out[n] = |hits;
  end

  AST_ONLY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~LEGAL_MASK) == '0); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> irq_out == '0); // R9
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int N  = NUM_LINKS,
  parameter int L  = IRQ_LINES,
  parameter int RW = REG_W,
  parameter int CW = CNT_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [RW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [RW-1:0] rd_data,
  input  logic [N-1:0]  evt_raise,
  input  logic [N-1:0]  evt_drop,
  output logic [L-1:0]  irq_out
);
  logic [N-1:0][RW-1:0] regs_q;
  logic [N-1:0]         reg_change;
  logic [N-1:0]         active;
  logic [N-1:0][CW-1:0] cnt_q;

  pirq_link_regs #(.N(N), .RW(RW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .regs_q(regs_q), .reg_change(reg_change)
  );

  for (genvar i = 0; i < N; i++) begin : g_cnt
    pirq_link_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .up(evt_raise[i]), .dn(evt_drop[i]),
      .cnt_q(cnt_q[i]), .active(active[i])
    );

    // live reroute: old line dropped, new line taken at one edge
    AST_REROUTE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_change[i] && active[i] && !evt_drop[i] && link_routed(mask_reg(wr_data)))
      |=> irq_out[irq_field(regs_q[i])]); // R8
  end

  pirq_irq_combiner #(.N(N), .L(L), .RW(RW)) u_comb (
    .clk(clk), .rst_n(rst_n), .active(active), .regs_q(regs_q), .irq_out(irq_out)
  );
endmodule

// File: tb/pirq_router_tb_top.sv
`timescale 1ns/1ps
module pirq_router_tb_top;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_idx = 0, rd_idx = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [7:0] evt_raise = 0, evt_drop = 0;
  logic [15:0] irq_out;

  int total = 0, bad = 0;
  string tag = "R1";
  int m_reg [8];
  int m_cnt [8];
  bit done = 0;

  always #2.5 clk = ~clk;

  pirq_router dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .evt_raise(evt_raise), .evt_drop(evt_drop), .irq_out(irq_out));

  function automatic bit ok_irq(int n);
    return (n >= 3 && n <= 7) || (n >= 9 && n <= 12) || n == 14 || n == 15;
  endfunction

  function automatic int exp_irq();
    int r = 0;
    for (int i = 0; i < 8; i++)
      if (m_cnt[i] > 0 && m_reg[i] < 128 && ok_irq(m_reg[i] % 16))
        r |= (1 << (m_reg[i] % 16));
    return r;
  endfunction

  function automatic int exp_rd(int idx);
    if (idx >= 1 && idx <= 8) return m_reg[idx-1];
    return 0;
  endfunction

  task automatic check();
    total++;
    if (int'(irq_out) != exp_irq()) begin
      bad++;
      $display("FAIL %s irq_out act=%h exp=%h", tag, irq_out, exp_irq());
    end
    total++;
    if (int'(rd_data) != exp_rd(int'(rd_idx))) begin
      bad++;
      $display("FAIL %s rd_data[%0d] act=%h exp=%h", tag, rd_idx, rd_data, exp_rd(int'(rd_idx)));
    end
  endtask

  task automatic model_update();
    if (wr_en && wr_idx >= 1 && wr_idx <= 8)
      m_reg[wr_idx-1] = int'(wr_data) & 8'h8F;
    for (int i = 0; i < 8; i++) begin
      if (evt_raise[i] && !evt_drop[i] && m_cnt[i] < 15) m_cnt[i]++;
      else if (evt_drop[i] && !evt_raise[i] && m_cnt[i] > 0) m_cnt[i]--;
    end
  endtask

  // one cycle: check state, drive inputs, let edge happen, update model
  task automatic step(bit we, int wi, int wd, int ri, int up, int dn);
    @(negedge clk);
    check();
    wr_en = we; wr_idx = 4'(wi); wr_data = 8'(wd); rd_idx = 4'(ri);
    evt_raise = 8'(up); evt_drop = 8'(dn);
    @(posedge clk);
    model_update();
  endtask

  task automatic idle(int ri); step(0, 0, 0, ri, 0, 0); endtask
  task automatic wr(int wi, int wd); step(1, wi, wd, wi, 0, 0); endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_reg[i] = 128; m_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    // R1 reset state
    for (int i = 0; i <= 8; i++) begin
      @(negedge clk); rd_idx = 4'(i); #1; check();
    end
    @(negedge clk); rst_n = 1;
    idle(1);
    // R2 masking and index decode
    tag = "R2";
    wr(1, 8'hFF); idle(1);
    wr(2, 8'h35); idle(2);
    step(1, 0, 8'h03, 0, 0, 0);
    step(1, 9, 8'h04, 9, 0, 0);
    step(1, 15, 8'h05, 15, 0, 0);
    for (int i = 0; i <= 15; i++) idle(i);
    // R4 basic raise on routed link
    tag = "R4";
    wr(1, 8'h05); idle(1);
    step(0, 0, 0, 1, 8'h01, 0); idle(1); idle(1);
    // R3 illegal targets
    tag = "R3";
    wr(2, 8'h08); step(0, 0, 0, 2, 8'h02, 0); idle(2);
    wr(2, 8'h0D); idle(2); wr(2, 8'h02); idle(2); wr(2, 8'h00); idle(2);
    wr(2, 8'h01); idle(2);
    wr(2, 8'h0E); idle(2);
    // R9 sharing a line
    tag = "R9";
    wr(3, 8'h05); step(0, 0, 0, 3, 8'h04, 0); idle(3);
    step(0, 0, 0, 3, 0, 8'h01); idle(3);
    step(0, 0, 0, 3, 0, 8'h04); idle(3);
    // R5 drops at zero don't wrap
    tag = "R5";
    step(0, 0, 0, 1, 0, 8'h01); step(0, 0, 0, 1, 0, 8'h01); idle(1);
    step(0, 0, 0, 1, 8'h01, 0); idle(1);
    step(0, 0, 0, 1, 0, 8'h01); idle(1);
    // R6 saturation
    tag = "R6";
    for (int k = 0; k < 18; k++) step(0, 0, 0, 1, 8'h01, 0);
    for (int k = 0; k < 14; k++) step(0, 0, 0, 1, 0, 8'h01);
    idle(1);
    step(0, 0, 0, 1, 0, 8'h01); idle(1);
    // R7 simultaneous pulses cancel
    tag = "R7";
    step(0, 0, 0, 1, 8'h01, 8'h01); idle(1);
    step(0, 0, 0, 1, 8'h01, 0); step(0, 0, 0, 1, 8'h01, 8'h01); idle(1);
    step(0, 0, 0, 1, 0, 8'h01); idle(1);
    // R8 live rerouting
    tag = "R8";
    step(0, 0, 0, 1, 8'h01, 0); idle(1);
    wr(1, 8'h0B); idle(1);
    wr(1, 8'h80); idle(1);
    wr(1, 8'h0B); idle(1);
    wr(1, 8'h0B); idle(1);
    wr(1, 8'h8B); idle(1);
    wr(1, 8'h03); idle(1);
    step(0, 0, 0, 1, 8'hFF, 0); wr(4, 8'h0F); wr(5, 8'h09); wr(6, 8'h07);
    idle(4); step(0, 0, 0, 1, 0, 8'hFF); idle(1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (200000) @(posedge clk); total++; bad++;
        $display("FAIL watchdog act=timeout exp=done"); end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule